// File: doc/BRIEF.md
# Mel Filter Bank Log-Energy Engine

This block turns one frame of FFT output into a short vector of log-scaled mel band energies. Bins arrive on an AXI4-Stream slave port in ascending order from bin 0 to bin N/2, one complex bin per beat. The engine keeps only the real part, offsets it by 1.0 and squares it, and uses the result as an approximate power. It weights that power with triangular filter coefficients and sums one total per filter.

Coefficients come from a constant table with one 32-bit word per bin, holding two coefficients. Adjacent triangular filters overlap, but no bin is ever covered by more than two of them. For that reason two multiply-accumulate lanes work side by side: one lane serves even-numbered filters and the other serves odd-numbered filters. A second constant table gives the last nonzero bin of each filter. When that bin is accepted, the filter's sum is complete and is turned into floor(log2) of its integer part. The result goes out on an AXI4-Stream master port.

Frame size, filter count and both constant tables are elaboration parameters. A keyword-spotting front end places this block between an FFT and a small neural network classifier.

Top module: `melLogEnergy`

## Requirements
- R1: An input beat carries the bin's real part in in_tdata[15:0], as signed fixed point with 8 fractional bits. The imaginary part in in_tdata[31:16] has no effect on any output.
- R2: The power of a bin is (real + 1.0)^2. A real part of 0 therefore contributes exactly 1.0 times the coefficient.
- R3: Coefficient word b serves bin b. Bits [15:0] hold the coefficient of the even-numbered filter that is active at that bin. Bits [31:16] hold the coefficient of the odd-numbered filter. Both are unsigned with 15 fractional bits. A filter's sum is the exact, non-wrapping total of power times coefficient over the bins of the frame.
- R4: Filter m completes when the beat whose bin index equals last-bin entry m is accepted. Each completed filter produces one output word, and the words leave in ascending filter order.
- R5: out_tdata is the bit position of the highest set bit in the integer part of the filter sum. The integer part is the sum scaled by 2^-31. A sum below 1.0 gives 0.
- R6: out_tlast is high on the output word of the last filter (NUM_MELS-1) and low on every other word.
- R7: in_tready is low whenever an output word is held that the consumer has not accepted, so no result is ever lost.
- R8: A beat with in_tlast high, or a beat at bin N/2, ends the frame. The next beat is bin 0, and filters not yet complete are discarded with no output.
- R9: After reset, out_tvalid is low and in_tready is high.
- R10: While out_tvalid is high and out_tready is low, out_tdata and out_tlast stay unchanged and out_tvalid stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_tvalid | input | 1 | Bin beat valid |
| in_tready | output | 1 | Engine can accept a bin |
| in_tdata | input | 2*DATA_W | Imaginary part [31:16], real part [15:0] |
| in_tlast | input | 1 | Last bin of the frame |
| out_tvalid | output | 1 | Log result valid |
| out_tready | input | 1 | Consumer accepts the result |
| out_tdata | output | OUT_W | floor(log2) of the filter sum's integer part |
| out_tlast | output | 1 | Result belongs to the last filter |

## Verification
The assertions assume that the last-bin table is strictly increasing and stays below N/2 + 1. They also assume that no bin has nonzero coefficients for two filters of the same parity. Under these assumptions the two lanes never complete a filter in the same cycle.

The bench builds its own coefficient and last-bin tables, with band edges that widen as the filter index grows. Every triangle ends exactly where the filter two places later begins, so every stimulus frame stays within the assumptions. The stimulus then varies bin values, valid gaps and consumer stalls against these fixed tables.

// File: rtl/melEnginePkg.sv
package melEnginePkg;
  localparam int MAX_BINS  = 513;
  localparam int MAX_MELS  = 20;
  localparam int COEF_W    = 16;
  localparam int WORD_W    = 2 * COEF_W;
  localparam int LUT_W     = 10;
  localparam int IN_FRAC   = 8;
  localparam int COEF_FRAC = 15;

  typedef logic [MAX_BINS*WORD_W-1:0] romImage_t;
  typedef logic [MAX_MELS*LUT_W-1:0]  lutImage_t;

  typedef struct packed {
    logic take;      // a bin beat is accepted this cycle
    logic frameEnd;  // that beat closes the frame
    logic relEven;   // even lane finishes its filter
    logic relOdd;    // odd lane finishes its filter
    logic lastMel;   // the finished filter is the final one
  } ctrlStrobe_t;

  function automatic int edgeBin(int k, int nBins, int nMels);
    return (k * (nBins - 1)) / (nMels + 1);
  endfunction

  function automatic romImage_t uniformRom(int frameSize, int nMels);
    romImage_t img;
    int nBins;
    img = '0;
    nBins = frameSize / 2 + 1;
    for (int m = 0; m < nMels; m++) begin
      int lo, pk, hi, c;
      lo = edgeBin(m, nBins, nMels);
      pk = edgeBin(m + 1, nBins, nMels);
      hi = edgeBin(m + 2, nBins, nMels);
      for (int b = lo + 1; b < hi; b++) begin
        if (b <= pk) c = ((b - lo) * 32768) / (pk - lo);
        else         c = ((hi - b) * 32768) / (hi - pk);
        if (m % 2 == 1) img[b*WORD_W+COEF_W +: COEF_W] = COEF_W'(c);
        else            img[b*WORD_W +: COEF_W]        = COEF_W'(c);
      end
    end
    return img;
  endfunction

  function automatic lutImage_t uniformLut(int frameSize, int nMels);
    lutImage_t lut;
    int nBins;
    lut = '0;
    nBins = frameSize / 2 + 1;
    for (int m = 0; m < nMels; m++)
      lut[m*LUT_W +: LUT_W] = LUT_W'(edgeBin(m + 2, nBins, nMels) - 1);
    return lut;
  endfunction
endpackage

// File: rtl/melCtrl.sv
module melCtrl import melEnginePkg::*; #(
  parameter int        NUM_BINS = 65,
  parameter int        NUM_MELS = 10,
  parameter lutImage_t LAST_BIN = '0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        inFire,
  input  logic                        inLast,
  output ctrlStrobe_t                 strb,
  output logic [$clog2(NUM_BINS)-1:0] binAddr
);
  localparam int ADDR_W = $clog2(NUM_BINS);
  localparam int TAB_N  = NUM_MELS + 2;
  localparam int IDX_W  = $clog2(TAB_N);

  logic [ADDR_W-1:0] binIdx;
  logic [IDX_W-1:0]  evIdx, odIdx;
  logic [LUT_W-1:0]  lastTab [TAB_N];
  logic              evLive, odLive, frameEnd;

  for (genvar m = 0; m < TAB_N; m++) begin : g_lut
    if (m < NUM_MELS) begin : g_real
      assign lastTab[m] = LAST_BIN[m*LUT_W +: LUT_W];
    end else begin : g_pad
      assign lastTab[m] = '1;
    end
  end

  always_comb begin
    evLive        = int'(evIdx) < NUM_MELS;
    odLive        = int'(odIdx) < NUM_MELS;
    frameEnd      = inFire && (inLast || binIdx == ADDR_W'(NUM_BINS - 1));
    strb.take     = inFire;
    strb.frameEnd = frameEnd;
    strb.relEven  = inFire && evLive && (LUT_W'(binIdx) == lastTab[evIdx]);
    strb.relOdd   = inFire && odLive && (LUT_W'(binIdx) == lastTab[odIdx]);
    strb.lastMel  = strb.relOdd ? (int'(odIdx) == NUM_MELS - 1)
                                : (int'(evIdx) == NUM_MELS - 1);
  end

  assign binAddr = binIdx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      binIdx <= '0;
      evIdx  <= IDX_W'(0);
      odIdx  <= IDX_W'(1);
    end else if (inFire) begin
      if (frameEnd) begin
        binIdx <= '0;
        evIdx  <= IDX_W'(0);
        odIdx  <= IDX_W'(1);
      end else begin
        binIdx <= binIdx + 1'b1;
        if (strb.relEven) evIdx <= evIdx + IDX_W'(2);
        if (strb.relOdd)  odIdx <= odIdx + IDX_W'(2);
      end
    end
  end

  AST_ONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.relEven && strb.relOdd)); // R4
  AST_LAST_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (inFire && inLast) |=> (binIdx == '0 && evIdx == IDX_W'(0))); // R8
  AST_BIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(binIdx) < NUM_BINS); // R8
endmodule

// File: rtl/melDatapath.sv
module melDatapath import melEnginePkg::*; #(
  parameter int        NUM_BINS = 65,
  parameter int        DATA_W   = 16,
  parameter int        OUT_W    = 8,
  parameter romImage_t COEF_ROM = '0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  ctrlStrobe_t                 strb,
  input  logic [$clog2(NUM_BINS)-1:0] binAddr,
  input  logic [DATA_W-1:0]           inReal,
  input  logic                        outReady,
  output logic                        outValid,
  output logic [OUT_W-1:0]            outData,
  output logic                        outLast
);
  localparam int ADDR_W = $clog2(NUM_BINS);
  localparam int ROM_N  = 1 << ADDR_W;
  localparam int SUM_W  = DATA_W + 1;
  localparam int POW_W  = 2 * SUM_W;
  localparam int PROD_W = POW_W + COEF_W;
  localparam int ACC_W  = PROD_W + $clog2(NUM_BINS + 1);
  localparam int FRAC   = 2 * IN_FRAC + COEF_FRAC;
  localparam int INT_W  = ACC_W - FRAC;
  localparam int LOG_W  = $clog2(INT_W);
  localparam logic signed [SUM_W-1:0] ONE_Q = SUM_W'(1 << IN_FRAC);

  logic [WORD_W-1:0] romTab [ROM_N];
  for (genvar b = 0; b < ROM_N; b++) begin : g_rom
    if (b < NUM_BINS) begin : g_word
      assign romTab[b] = COEF_ROM[b*WORD_W +: WORD_W];
    end else begin : g_zero
      assign romTab[b] = '0;
    end
  end

  logic signed [SUM_W-1:0] biased;
  logic signed [POW_W-1:0] square;
  logic [POW_W-1:0]        power;
  logic [COEF_W-1:0]       evCoef, odCoef;
  logic [PROD_W-1:0]       evProd, odProd;
  logic [ACC_W-1:0]        evAcc, odAcc, evNext, odNext, relSum;
  logic [INT_W-1:0]        intPart;
  logic [LOG_W-1:0]        relLog;
  logic                    release_;

  assign biased  = SUM_W'(signed'(inReal)) + ONE_Q;
  assign square  = biased * biased;
  assign power   = unsigned'(square);
  assign evCoef  = romTab[binAddr][COEF_W-1:0];
  assign odCoef  = romTab[binAddr][WORD_W-1:COEF_W];
  assign evProd  = PROD_W'(power) * PROD_W'(evCoef);
  assign odProd  = PROD_W'(power) * PROD_W'(odCoef);
  assign evNext  = evAcc + ACC_W'(evProd);
  assign odNext  = odAcc + ACC_W'(odProd);
  assign relSum  = strb.relOdd ? odNext : evNext;
  assign intPart = relSum[ACC_W-1:FRAC];
  assign release_ = strb.relEven || strb.relOdd;

  always_comb begin
    relLog = '0;
    for (int i = 0; i < INT_W; i++)
      if (intPart[i]) relLog = LOG_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evAcc <= '0;
      odAcc <= '0;
    end else if (strb.take) begin
      evAcc <= (strb.relEven || strb.frameEnd) ? '0 : evNext;
      odAcc <= (strb.relOdd  || strb.frameEnd) ? '0 : odNext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outData  <= '0;
      outLast  <= 1'b0;
    end else if (release_) begin
      outValid <= 1'b1;
      outData  <= OUT_W'(relLog);
      outLast  <= strb.lastMel;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    strb.take |-> (evNext >= evAcc && odNext >= odAcc)); // R3
  AST_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    release_ |-> (!outValid || outReady)); // R7
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast))); // R10
  AST_LOG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> int'(outData) < INT_W); // R5
endmodule

// File: rtl/melLogEnergy.sv
module melLogEnergy import melEnginePkg::*; #(
  parameter int        FRAME_SIZE = 128,
  parameter int        NUM_MELS   = 10,
  parameter int        DATA_W     = 16,
  parameter int        OUT_W      = 8,
  parameter romImage_t COEF_ROM   = uniformRom(FRAME_SIZE, NUM_MELS),
  parameter lutImage_t LAST_BIN   = uniformLut(FRAME_SIZE, NUM_MELS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_tvalid,
  output logic                in_tready,
  input  logic [2*DATA_W-1:0] in_tdata,
  input  logic                in_tlast,
  output logic                out_tvalid,
  input  logic                out_tready,
  output logic [OUT_W-1:0]    out_tdata,
  output logic                out_tlast
);
  localparam int NUM_BINS = FRAME_SIZE / 2 + 1;
  localparam int ADDR_W   = $clog2(NUM_BINS);

  ctrlStrobe_t       strb;
  logic [ADDR_W-1:0] binAddr;
  logic              inFire;

  assign in_tready = !out_tvalid || out_tready;
  assign inFire    = in_tvalid && in_tready;

  melCtrl #(.NUM_BINS(NUM_BINS), .NUM_MELS(NUM_MELS), .LAST_BIN(LAST_BIN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .inFire(inFire), .inLast(in_tlast),
    .strb(strb), .binAddr(binAddr));

  melDatapath #(.NUM_BINS(NUM_BINS), .DATA_W(DATA_W), .OUT_W(OUT_W),
                .COEF_ROM(COEF_ROM)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .binAddr(binAddr),
    .inReal(in_tdata[DATA_W-1:0]), .outReady(out_tready),
    .outValid(out_tvalid), .outData(out_tdata), .outLast(out_tlast));
endmodule

// File: tb/sim_melLogEnergy.sv
`timescale 1ns/1ps
module sim_melLogEnergy;
  import melEnginePkg::*;

  localparam int FS = 128;
  localparam int NB = FS / 2 + 1;
  localparam int M  = 10;

  function automatic int bEdge(int k);
    return (k * (k + 3) * (NB - 1)) / ((M + 1) * (M + 4));
  endfunction
  function automatic int coefOf(int m, int b);
    int lo, pk, hi;
    lo = bEdge(m); pk = bEdge(m + 1); hi = bEdge(m + 2);
    if (b > lo && b <= pk) return ((b - lo) * 32768) / (pk - lo);
    if (b > pk && b < hi)  return ((hi - b) * 32768) / (hi - pk);
    return 0;
  endfunction
  function automatic int lastOf(int m);
    return bEdge(m + 2) - 1;
  endfunction
  function automatic romImage_t benchRom();
    romImage_t r;
    r = '0;
    for (int m = 0; m < M; m++)
      for (int b = 0; b < NB; b++)
        if (coefOf(m, b) != 0) begin
          if (m % 2 == 1) r[b*32+16 +: 16] = 16'(coefOf(m, b));
          else            r[b*32 +: 16]    = 16'(coefOf(m, b));
        end
    return r;
  endfunction
  function automatic lutImage_t benchLut();
    lutImage_t l;
    l = '0;
    for (int m = 0; m < M; m++) l[m*10 +: 10] = 10'(lastOf(m));
    return l;
  endfunction

  localparam romImage_t BROM = benchRom();
  localparam lutImage_t BLUT = benchLut();

  logic clk = 0, rst_n = 0;
  logic in_tvalid = 0, in_tlast = 0, out_tready = 0;
  logic [31:0] in_tdata = '0;
  logic in_tready, out_tvalid, out_tlast;
  logic [7:0] out_tdata;

  melLogEnergy #(.FRAME_SIZE(FS), .NUM_MELS(M), .COEF_ROM(BROM), .LAST_BIN(BLUT)) u0 (
    .clk(clk), .rst_n(rst_n), .in_tvalid(in_tvalid), .in_tready(in_tready),
    .in_tdata(in_tdata), .in_tlast(in_tlast), .out_tvalid(out_tvalid),
    .out_tready(out_tready), .out_tdata(out_tdata), .out_tlast(out_tlast));

  always #2.5 clk = ~clk;

  int nChecks = 0, nFail = 0, readyPct = 100, gotN = 0;
  int gotLog [0:1023];
  bit gotLast [0:1023];
  logic signed [15:0] frRe [NB];
  logic [15:0] frIm [NB];
  bit inFire = 0, stalled = 0, stLast = 0;
  logic [7:0] stData = '0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    inFire <= in_tvalid && in_tready;
    if (rst_n && out_tvalid && out_tready) begin
      gotLog[gotN]  <= int'(out_tdata);
      gotLast[gotN] <= out_tlast;
      gotN <= gotN + 1;
    end
    if (rst_n && stalled)  // R10
      check(out_tvalid && out_tdata == stData && out_tlast == stLast,
            "R10", "held word", longint'(out_tdata), longint'(stData));
    stalled <= rst_n && out_tvalid && !out_tready;
    stData  <= out_tdata;
    stLast  <= out_tlast;
  end

  always @(negedge clk) begin
    if (rst_n && out_tvalid && !out_tready)  // R7
      check(in_tready == 1'b0, "R7", "in_tready under stall", longint'(in_tready), 0);
    out_tready <= ($urandom % 100) < readyPct;
  end

  function automatic int expLog(int m);
    longint s, ip;
    int lg;
    s = 0;
    for (int b = 0; b <= lastOf(m); b++) begin
      longint v;
      v = longint'(int'(frRe[b]) + 256);
      s += v * v * longint'(coefOf(m, b));
    end
    ip = s >>> 31;
    lg = 0;
    for (int i = 0; i < 40; i++) if ((ip >>> i) != 0) lg = i;
    return lg;
  endfunction

  task automatic fill(int kind);
    for (int b = 0; b < NB; b++) begin
      case (kind)
        0: frRe[b] = -16'sd256;
        1: frRe[b] = 16'sd0;
        2: frRe[b] = 16'sd32767;
        3: frRe[b] = -16'sd32768;
        4: frRe[b] = 16'($urandom);
        5: frRe[b] = 16'(int'($urandom % 1024) - 512);
        default: ;
      endcase
      frIm[b] = (kind == 6) ? 16'($urandom) : 16'h0;
    end
  endtask

  task automatic sendFrame(int len, bit useLast, int gapPct);
    for (int b = 0; b < len; b++) begin
      while (($urandom % 100) < gapPct) @(negedge clk);
      in_tvalid = 1;
      in_tdata  = {frIm[b], frRe[b]};
      in_tlast  = useLast && (b == len - 1);
      do @(negedge clk); while (!inFire);
      in_tvalid = 0;
      in_tlast  = 0;
    end
  endtask

  task automatic runFrame(int kind, int len, bit useLast, int gapPct, int rdy, string req);
    int base, expN, k, w;
    int expM [M];
    readyPct = rdy;
    fill(kind);
    base = gotN;
    expN = 0;
    for (int m = 0; m < M; m++)
      if (lastOf(m) < len) begin expM[expN] = m; expN++; end
    sendFrame(len, useLast, gapPct);
    w = 0;
    while (gotN < base + expN && w < 2000) begin @(negedge clk); w++; end
    repeat (6) @(negedge clk);
    check(gotN - base == expN, "R4", "word count", gotN - base, expN);
    for (k = 0; k < expN && base + k < gotN; k++) begin
      check(gotLog[base+k] == expLog(expM[k]), req, "log value",
            gotLog[base+k], expLog(expM[k]));
      check(gotLast[base+k] == (expM[k] == M - 1), "R6", "out_tlast",
            gotLast[base+k], (expM[k] == M - 1));
    end
  endtask

  initial begin
    #(5.0 * 150000);
    check(0, "WATCHDOG", "run did not finish", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd9173));
    repeat (4) @(negedge clk);
    check(out_tvalid == 1'b0, "R9", "out_tvalid in reset", longint'(out_tvalid), 0);
    check(in_tready == 1'b1, "R9", "in_tready in reset", longint'(in_tready), 1);
    rst_n = 1;
    @(negedge clk);
    check(out_tvalid == 1'b0 && in_tready == 1'b1, "R9", "idle after reset",
          longint'(out_tvalid), 0);
    runFrame(0, NB, 1, 0, 100, "R5");   // zero power: every sum below 1.0
    runFrame(1, NB, 1, 0, 100, "R2");   // real part 0: power exactly 1.0
    runFrame(2, NB, 1, 10, 60, "R3");   // largest positive sample
    runFrame(3, NB, 1, 10, 60, "R3");   // most negative sample
    for (int i = 0; i < 8; i++) runFrame(4, NB, 1, 20, 30 + 10 * i, "R3");
    for (int i = 0; i < 4; i++) runFrame(5, NB, 1, 30, 15, "R2");
    runFrame(5, NB, 1, 0, 100, "R1");   // R1: same reals, imaginary zero
    runFrame(6, NB, 1, 0, 100, "R1");   // R1: same reals, imaginary random
    runFrame(4, 20, 1, 0, 100, "R8");   // R8: frame cut short by in_tlast
    runFrame(4, NB, 1, 10, 70, "R8");   // R8: following frame starts at bin 0
    runFrame(4, NB, 0, 10, 70, "R8");   // R8: frame ends at bin N/2 without in_tlast
    runFrame(4, NB, 1, 0, 5, "R7");     // R7: heavy output backpressure
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule